// File: doc/BRIEF.md
# UART Register Bank with Switchable Divisor Window

This block is the processor-facing register file of a UART. It decodes a small word-addressed register bus and holds the line configuration, the interrupt-enable bits and the 16-bit baud divisor. It does not shift bits: it hands a transmit byte and a load pulse to the transmit shifter, pulses the receive side when the receive buffer is read, and gives the baud-tick generator and the shifters the divisor and the decoded frame settings.

Two bus offsets are windows shared by two registers each. A latch-select bit in the line configuration register picks which set the windows show: the data path (receive buffer on reads, transmit holding on writes) together with interrupt enable, or the two halves of the divisor. Two further offsets always reach the divisor halves, so a driver that uses them never has to toggle the latch-select bit.

Top module: `uart_regbank`

## Requirements
- R1: After synchronous reset the line configuration, interrupt enable and divisor are zero, tx_load and rx_read are low, data_bits is 5 and par_mode is 0.
- R2: With latch-select (line configuration bit 7) at 0, a write to offset 0 puts wdata[7:0] on tx_data and raises tx_load for exactly the next cycle. A read of offset 0 returns rx_byte in the same cycle and raises rx_read for exactly the next cycle.
- R3: With latch-select at 0, offset 1 reads and writes interrupt enable. Only the low IER_BITS (default 4) bits are kept, and the bits above them read as zero.
- R4: With latch-select at 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. These accesses raise neither tx_load nor rx_read. The divisor output holds the new value from the clock edge that takes the write.
- R5: Offset 8 (divisor low) and offset 9 (divisor high) read and write the divisor whatever the latch-select bit is.
- R6: Offset 3 is the line configuration register. Bits [7:0] read back as written and bits 31:8 read as zero. The fields are: [1:0] word-length code, 2 long-stop, 3 parity enable, 4 even select, 5 stick, 6 break, 7 latch-select.
- R7: data_bits is 5 plus the word-length code. stop_halves gives the stop length in half-bit units: 2 when long-stop is 0, 3 when long-stop is 1 and the code is 0, and 4 otherwise.
- R8: par_mode is 0 with parity disabled. With parity enabled it is 1 (odd) or 2 (even) when stick is 0, and 3 (parity bit always 1) or 4 (parity bit always 0) when stick is 1. Even select 0 gives the first value of each pair.
- R9: A read of offset 5 returns line_status zero-extended.
- R10: A read of any other offset returns zero, and a write to one changes no register. rdata is zero in any cycle where rd is low.
- R11: brk drives the break field (line configuration bit 6) and dlab the latch-select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word offset of the access |
| wdata | input | BUS_W | Write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| rdata | output | BUS_W | Read data, valid in the cycle rd is high |
| rx_byte | input | 8 | Byte held by the receive buffer |
| line_status | input | 8 | Line status flags from the receive and transmit sides |
| tx_data | output | 8 | Byte for the transmit shifter |
| tx_load | output | 1 | One-cycle transmit load pulse |
| rx_read | output | 1 | One-cycle pulse that clears receive data-ready |
| ier | output | IER_BITS | Interrupt enable bits |
| divisor | output | 16 | Baud divisor, high byte first |
| word_code | output | 2 | Word-length code |
| data_bits | output | 4 | Data bits per character |
| stop_halves | output | 3 | Stop length in half-bit units |
| par_mode | output | 3 | Parity mode code |
| brk | output | 1 | Force the line to the spacing state |
| dlab | output | 1 | Latch-select bit |

## Verification
The hard case is the aliasing itself: the same offset must reach different storage depending on a bit written earlier. The visible proof is that a register is left alone when its alias is used. The stimulus writes the divisor through a dedicated offset, then sets latch-select and reads that value back through the shared window. It writes the high byte through the shared window and reads it back through the dedicated offset. After latch-select is cleared again, it confirms that interrupt enable still holds its earlier value and that no transmit load pulse came from the divisor writes.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int OFS_WIN_LO = 0;
    localparam int OFS_WIN_HI = 1;
    localparam int OFS_LINE   = 3;
    localparam int OFS_STAT   = 5;
    localparam int OFS_DIV_LO = 8;
    localparam int OFS_DIV_HI = 9;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DATA = 3'd1,
        SEL_IER  = 3'd2,
        SEL_DLO  = 3'd3,
        SEL_DHI  = 3'd4,
        SEL_LINE = 3'd5,
        SEL_STAT = 3'd6
    } reg_sel_e;

    // bit order matches the register layout, MSB first
    typedef struct packed {
        logic       latch_sel;
        logic       brk;
        logic       stick;
        logic       even;
        logic       pen;
        logic       long_stop;
        logic [1:0] wcode;
    } line_cfg_t;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_ONE   = 3'd3,
        PAR_ZERO  = 3'd4
    } par_mode_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        reg_sel_e   sel;
        logic [7:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_sel(input int unsigned ofs, input logic latch);
        reg_sel_e s;
        case (ofs)
            OFS_WIN_LO: s = latch ? SEL_DLO : SEL_DATA;
            OFS_WIN_HI: s = latch ? SEL_DHI : SEL_IER;
            OFS_LINE:   s = SEL_LINE;
            OFS_STAT:   s = SEL_STAT;
            OFS_DIV_LO: s = SEL_DLO;
            OFS_DIV_HI: s = SEL_DHI;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [3:0] calc_data_bits(input logic [1:0] wcode);
        return 4'd5 + {2'b00, wcode};
    endfunction

    function automatic logic [2:0] calc_stop_halves(input logic long_stop, input logic [1:0] wcode);
        if (!long_stop)
            return 3'd2;
        else if (wcode == 2'd0)
            return 3'd3;
        else
            return 3'd4;
    endfunction

    function automatic par_mode_e calc_par(input logic pen, input logic even, input logic stick);
        par_mode_e m;
        if (!pen)
            m = PAR_NONE;
        else if (!stick)
            m = even ? PAR_EVEN : PAR_ODD;
        else
            m = even ? PAR_ZERO : PAR_ONE;
        return m;
    endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BUS_W  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic              latch_sel,
    output bus_req_t          req
);

    always_comb begin
        req.wr   = wr;
        req.rd   = rd;
        req.sel  = decode_sel(32'(addr), latch_sel);
        req.data = wdata[7:0];
    end

endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
    import uart_rb_pkg::*;
#(
    parameter int IER_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            req,
    output line_cfg_t           line_q,
    output logic [IER_BITS-1:0] ier_q,
    output logic [7:0]          dlo_q,
    output logic [7:0]          dhi_q,
    output logic [7:0]          thr_q,
    output logic                load_q,
    output logic                rxrd_q
);

    logic wr_data, wr_ier, wr_dlo, wr_dhi, wr_line, rd_data;

    always_comb begin
        wr_data = req.wr && (req.sel == SEL_DATA);
        wr_ier  = req.wr && (req.sel == SEL_IER);
        wr_dlo  = req.wr && (req.sel == SEL_DLO);
        wr_dhi  = req.wr && (req.sel == SEL_DHI);
        wr_line = req.wr && (req.sel == SEL_LINE);
        rd_data = req.rd && (req.sel == SEL_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            ier_q  <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
            thr_q  <= '0;
            load_q <= 1'b0;
            rxrd_q <= 1'b0;
        end else begin
            if (wr_line) line_q <= line_cfg_t'(req.data);
            if (wr_ier)  ier_q  <= req.data[IER_BITS-1:0];
            if (wr_dlo)  dlo_q  <= req.data;
            if (wr_dhi)  dhi_q  <= req.data;
            if (wr_data) thr_q  <= req.data;
            load_q <= wr_data;
            rxrd_q <= rd_data;
        end
    end

    // R2
    thr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_DATA) |=> (load_q && thr_q == $past(req.data)));

    // R2
    rbr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == SEL_DATA) |=> rxrd_q);

    // R4
    div_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_DLO) |=> (!load_q && dlo_q == $past(req.data)));

    // R10
    undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_NONE) |=>
            ($stable(line_q) && $stable(ier_q) && $stable(dlo_q) && $stable(dhi_q) && !load_q));

endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
    import uart_rb_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int IER_BITS = 4
) (
    input  bus_req_t            req,
    input  line_cfg_t           line_q,
    input  logic [IER_BITS-1:0] ier_q,
    input  logic [7:0]          dlo_q,
    input  logic [7:0]          dhi_q,
    input  logic [7:0]          rx_byte,
    input  logic [7:0]          line_status,
    output logic [BUS_W-1:0]    rdata
);

    logic [7:0] byte_sel;

    always_comb begin
        case (req.sel)
            SEL_DATA: byte_sel = rx_byte;
            SEL_IER:  byte_sel = 8'(ier_q);
            SEL_DLO:  byte_sel = dlo_q;
            SEL_DHI:  byte_sel = dhi_q;
            SEL_LINE: byte_sel = line_q;
            SEL_STAT: byte_sel = line_status;
            default:  byte_sel = 8'h00;
        endcase
        rdata = req.rd ? BUS_W'(byte_sel) : '0;
    end

endmodule

// File: rtl/uart_rb_frame.sv
module uart_rb_frame
    import uart_rb_pkg::*;
(
    input  line_cfg_t  line_q,
    output logic [3:0] data_bits,
    output logic [2:0] stop_halves,
    output par_mode_e  par_mode
);

    always_comb begin
        data_bits   = calc_data_bits(line_q.wcode);
        stop_halves = calc_stop_halves(line_q.long_stop, line_q.wcode);
        par_mode    = calc_par(line_q.pen, line_q.even, line_q.stick);
    end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int BUS_W    = 32,
    parameter int IER_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    input  logic                wr,
    input  logic                rd,
    output logic [BUS_W-1:0]    rdata,
    input  logic [7:0]          rx_byte,
    input  logic [7:0]          line_status,
    output logic [7:0]          tx_data,
    output logic                tx_load,
    output logic                rx_read,
    output logic [IER_BITS-1:0] ier,
    output logic [15:0]         divisor,
    output logic [1:0]          word_code,
    output logic [3:0]          data_bits,
    output logic [2:0]          stop_halves,
    output logic [2:0]          par_mode,
    output logic                brk,
    output logic                dlab
);

    bus_req_t  req;
    line_cfg_t line_q;
    logic [7:0] dlo_q, dhi_q;
    par_mode_e par_e;

    uart_rb_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
        .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .latch_sel(line_q.latch_sel), .req(req)
    );

    uart_rb_regs #(.IER_BITS(IER_BITS)) u_regs (
        .clk(clk), .rst(rst), .req(req), .line_q(line_q), .ier_q(ier),
        .dlo_q(dlo_q), .dhi_q(dhi_q), .thr_q(tx_data),
        .load_q(tx_load), .rxrd_q(rx_read)
    );

    uart_rb_rdmux #(.BUS_W(BUS_W), .IER_BITS(IER_BITS)) u_mux (
        .req(req), .line_q(line_q), .ier_q(ier), .dlo_q(dlo_q), .dhi_q(dhi_q),
        .rx_byte(rx_byte), .line_status(line_status), .rdata(rdata)
    );

    uart_rb_frame u_frame (
        .line_q(line_q), .data_bits(data_bits),
        .stop_halves(stop_halves), .par_mode(par_e)
    );

    always_comb begin
        divisor   = {dhi_q, dlo_q};
        word_code = line_q.wcode;
        par_mode  = par_e;
        brk       = line_q.brk;
        dlab      = line_q.latch_sel;
    end

    // R7
    stop_range_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_halves >= 3'd2) && (stop_halves <= 3'd4)
        && ((stop_halves == 3'd3) -> (data_bits == 4'd5)));

    // R8
    par_off_chk: assert property (@(posedge clk) disable iff (rst)
        (par_mode == 3'd0) == !line_q.pen);

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (rdata == '0));

    // R4
    alias_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && dlab) |=> !tx_load);

endmodule

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        wr, rd;
    logic [31:0] rdata;
    logic [7:0]  rx_byte, line_status, tx_data;
    logic        tx_load, rx_read, brk, dlab;
    logic [3:0]  ier;
    logic [15:0] divisor;
    logic [1:0]  word_code;
    logic [3:0]  data_bits;
    logic [2:0]  stop_halves, par_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_regbank u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .rx_byte(rx_byte), .line_status(line_status),
        .tx_data(tx_data), .tx_load(tx_load), .rx_read(rx_read), .ier(ier),
        .divisor(divisor), .word_code(word_code), .data_bits(data_bits),
        .stop_halves(stop_halves), .par_mode(par_mode), .brk(brk), .dlab(dlab)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #5 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    // vector: {is_write, offset[3:0], data[7:0], expected read[31:0]}
    localparam int NV = 17;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 4'd3,  8'h03, 32'h0},          // R6 line cfg, latch 0
        {1'b0, 4'd3,  8'h00, 32'h0000_0003},  // R6
        {1'b1, 4'd1,  8'hFF, 32'h0},          // R3 interrupt enable
        {1'b0, 4'd1,  8'h00, 32'h0000_000F},  // R3 upper bits zero
        {1'b1, 4'd8,  8'h34, 32'h0},          // R5 dedicated low
        {1'b0, 4'd8,  8'h00, 32'h0000_0034},  // R5
        {1'b1, 4'd3,  8'h83, 32'h0},          // R4 latch-select on
        {1'b0, 4'd0,  8'h00, 32'h0000_0034},  // R4 low via window
        {1'b1, 4'd1,  8'h12, 32'h0},          // R4 high via window
        {1'b0, 4'd9,  8'h00, 32'h0000_0012},  // R5 dedicated high
        {1'b0, 4'd1,  8'h00, 32'h0000_0012},  // R4
        {1'b1, 4'd3,  8'h03, 32'h0},          // latch-select off
        {1'b0, 4'd1,  8'h00, 32'h0000_000F},  // R3 enable untouched
        {1'b1, 4'd2,  8'h55, 32'h0},          // R10 undefined write
        {1'b0, 4'd2,  8'h00, 32'h0},          // R10
        {1'b0, 4'd7,  8'h00, 32'h0},          // R10
        {1'b0, 4'd15, 8'h00, 32'h0}           // R10
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
        rx_byte = 8'hA5; line_status = 8'h61;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 divisor", 32'(divisor), 32'h0);
        check("R1 ier", 32'(ier), 32'h0);
        check("R1 strobes", {30'b0, tx_load, rx_read}, 32'h0);
        check("R1 data_bits", 32'(data_bits), 32'd5);
        check("R1 par_mode", 32'(par_mode), 32'd0);
        bus_read(4'd3, r);
        check("R1 line cfg", r, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                bus_write(VEC[i][43:40], {24'h0, VEC[i][39:32]});
            end else begin
                bus_read(VEC[i][43:40], r);
                check($sformatf("vector %0d", i), r, VEC[i][31:0]);
            end
        end
        check("R4 divisor output", 32'(divisor), 32'h1234);
        check("R10 no load from alias writes", 32'(tx_load), 32'h0);

        // R2 transmit load pulse
        bus_write(4'd0, 32'h0000_005A);
        check("R2 tx_load high", 32'(tx_load), 32'h1);
        check("R2 tx_data", 32'(tx_data), 32'h5A);
        @(negedge clk);
        check("R2 tx_load one cycle", 32'(tx_load), 32'h0);
        check("R4 divisor kept by data write", 32'(divisor), 32'h1234);

        // R2 receive read pulse
        bus_read(4'd0, r);
        check("R2 rbr data", r, 32'h0000_00A5);
        check("R2 rx_read high", 32'(rx_read), 32'h1);
        @(negedge clk);
        check("R2 rx_read one cycle", 32'(rx_read), 32'h0);

        // R4 divisor update timing and no strobe
        bus_write(4'd3, 32'h80);
        check("R11 dlab", 32'(dlab), 32'h1);
        bus_write(4'd0, 32'hC3);
        check("R4 divisor after window write", 32'(divisor), 32'h12C3);
        check("R4 no tx_load", 32'(tx_load), 32'h0);
        bus_read(4'd0, r);
        check("R4 no rx_read", 32'(rx_read), 32'h0);
        bus_write(4'd9, 32'h7E);
        check("R5 dedicated high with latch on", 32'(divisor), 32'h7EC3);

        // R9 status
        bus_read(4'd5, r);
        check("R9 status", r, 32'h0000_0061);

        // R6 upper bits, R11 break
        bus_write(4'd3, 32'hFFFF_FF4B);
        bus_read(4'd3, r);
        check("R6 line cfg upper zero", r, 32'h0000_004B);
        check("R11 brk", 32'(brk), 32'h1);
        check("R11 dlab low", 32'(dlab), 32'h0);

        // R10 idle rdata
        @(negedge clk);
        addr = 4'd5;
        #5 check("R10 rdata idle", rdata, 32'h0);

        // R7 / R8 every frame setting
        for (int v = 0; v < 64; v++) begin
            logic [7:0] cfg;
            logic [2:0] est;
            logic [2:0] epar;
            cfg = 8'(v);
            bus_write(4'd3, {24'h0, cfg});
            if (!cfg[2]) est = 3'd2;
            else if (cfg[1:0] == 2'd0) est = 3'd3;
            else est = 3'd4;
            if (!cfg[3]) epar = 3'd0;
            else if (!cfg[5]) epar = cfg[4] ? 3'd2 : 3'd1;
            else epar = cfg[4] ? 3'd4 : 3'd3;
            check("R7 frame", {21'b0, data_bits, stop_halves, word_code, 2'b0},
                  {21'b0, 4'd5 + {2'b0, cfg[1:0]}, est, cfg[1:0], 2'b0});
            check("R8 parity", 32'(par_mode), 32'(epar));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule